// File: doc/BRIEF.md
# Memory-Operand ALU Execute Stage

This block is the execute stage of a 32-bit core whose arithmetic instructions need not be load/store. Each instruction performs add, subtract, AND, OR or XOR on two operands. Either operand can come from a register, from a hardwired register that always reads all ones, or from a word of the scratchpad data memory. The result always goes to one of sixteen general registers.

The two operand positions accept different sources. The first operand can be a counter register, the all-ones constant, or a scratchpad word whose address is held in a counter register. The second operand can be a general register, the all-ones constant, or a scratchpad word addressed either by an immediate or by a second counter register. Any post-increment or post-decrement of a pointer is done by a separate address generator. This stage only issues the addresses.

An instruction is presented for one cycle with `issue_vld`. In that cycle the stage drives the scratchpad read requests. The scratchpad answers one cycle later, and the stage combines the returned words with the registered operands. It drives the register write port and the flags in that same next cycle. Every instruction has the same one-cycle latency, whatever its sources.

Top module: `mop_alu_exec`

## Requirements
- R1: The `issue_op` codes are 0 = add, 1 = subtract (first operand minus second), 2 = AND, 3 = OR, 4 = XOR. Codes 5, 6 and 7 are illegal.
- R2: The `src_a_sel` codes are 0 = counter register value `cnt_a_data`, 1 = all-ones constant, 2 = scratchpad word at address `cnt_a_data[AW-1:0]`. Code 3 (an immediate-addressed word) is illegal for the first operand.
- R3: The `src_b_sel` codes are 0 = general register value `gen_b_data`, 1 = all-ones constant, 2 = scratchpad word at address `imm_addr`, 3 = scratchpad word at address `ptr_b_data`.
- R4: A source that selects the constant reads 0xFFFFFFFF.
- R5: In the issue cycle of a legal instruction, `mem_a_ren` is high exactly when `src_a_sel` = 2, and `mem_b_ren` is high exactly when `src_b_sel` is 2 or 3. Each address is the one named in R2 and R3.
- R6: One clock edge after a legal issue, `wr_en` is high for one cycle. In that cycle `wr_idx` equals the issued `dst_idx` and `wr_data` holds the result.
- R7: For add and subtract, `flag_c` is the carry out of bit 31. For subtract this is 1 when A >= B unsigned, meaning no borrow. `flag_v` is signed overflow, `flag_z` means a zero result and `flag_n` is result bit 31.
- R8: For AND, OR and XOR, `flag_c` and `flag_v` are 0, while `flag_z` and `flag_n` follow the result.
- R9: An issue with an illegal opcode or an illegal first-operand source raises `err` for one cycle, one edge later. It keeps `wr_en` low and issues no scratchpad read.
- R10: While reset is held, and in the first cycle after it, `wr_en`, `err` and all flags are 0.
- R11: A cycle without `issue_vld` requests no scratchpad read. It produces neither a write nor an error on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Instruction present this cycle |
| issue_op | input | 3 | Operation code (R1) |
| src_a_sel | input | 2 | First-operand source (R2) |
| src_b_sel | input | 2 | Second-operand source (R3) |
| dst_idx | input | 4 | Destination general register |
| cnt_a_data | input | 32 | Counter register read for the first operand or its pointer |
| ptr_b_data | input | 16 | Counter register pointer for the second operand |
| gen_b_data | input | 32 | General register read for the second operand |
| imm_addr | input | 16 | Immediate scratchpad address for the second operand |
| mem_a_ren | output | 1 | Scratchpad read request, first operand |
| mem_a_addr | output | 16 | Scratchpad address, first operand |
| mem_b_ren | output | 1 | Scratchpad read request, second operand |
| mem_b_addr | output | 16 | Scratchpad address, second operand |
| mem_a_rdata | input | 32 | Scratchpad data, one cycle after `mem_a_ren` |
| mem_b_rdata | input | 32 | Scratchpad data, one cycle after `mem_b_ren` |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 32 | Register write data |
| flag_c | output | 1 | Carry / no-borrow |
| flag_z | output | 1 | Zero result |
| flag_n | output | 1 | Negative result |
| flag_v | output | 1 | Signed overflow |
| err | output | 1 | Illegal instruction seen |

## Verification
The assertions check the cycle-level rules on every cycle:
- a write or an error never appears without an issue one edge earlier,
- the two never coincide,
- reads are never requested for idle or illegal issues,
- a first-operand code of 3 always yields an error,
- logical operations never raise carry or overflow.

The result values can only be shown by the bench's scenarios. The bench sweeps every opcode against every pairing of the two source selects, under corner data patterns and pseudo-random data. It compares each result, write index and flag against sums, differences and bitwise values it computes itself from a modelled scratchpad.

// File: rtl/mop_alu_pkg.sv
package mop_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  // first operand sources
  localparam logic [1:0] SA_CNT  = 2'd0;
  localparam logic [1:0] SA_ONES = 2'd1;
  localparam logic [1:0] SA_MEMP = 2'd2;
  localparam logic [1:0] SA_BAD  = 2'd3;

  // second operand sources
  localparam logic [1:0] SB_GEN  = 2'd0;
  localparam logic [1:0] SB_ONES = 2'd1;
  localparam logic [1:0] SB_MEMI = 2'd2;
  localparam logic [1:0] SB_MEMP = 2'd3;

  function automatic logic op_is_legal(input logic [2:0] op);
    return op <= 3'(OP_XOR);
  endfunction

  function automatic logic op_is_logic(input logic [2:0] op);
    return (op == 3'(OP_AND)) || (op == 3'(OP_OR)) || (op == 3'(OP_XOR));
  endfunction

endpackage

// File: rtl/mop_addr_sel.sv
module mop_addr_sel
  import mop_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          issue_ok,
  input  logic [1:0]    a_sel,
  input  logic [1:0]    b_sel,
  input  logic [DW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  input  logic [AW-1:0] imm,
  output logic          ren_a,
  output logic [AW-1:0] addr_a,
  output logic          ren_b,
  output logic [AW-1:0] addr_b
);

  logic b_uses_mem;

  assign b_uses_mem = (b_sel == SB_MEMI) || (b_sel == SB_MEMP);
  assign ren_a      = issue_ok && (a_sel == SA_MEMP);
  assign ren_b      = issue_ok && b_uses_mem;
  assign addr_a     = ptr_a[AW-1:0];
  assign addr_b     = (b_sel == SB_MEMI) ? imm : ptr_b;

endmodule

// File: rtl/mop_src_mux.sv
module mop_src_mux
  import mop_alu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int POS = 0
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] mem_val,
  output logic [DW-1:0] opnd
);

  localparam logic [DW-1:0] ALL_ONES = '1;

  generate
    if (POS == 0) begin : g_first
      always_comb begin
        unique case (sel)
          SA_CNT:  opnd = reg_val;
          SA_ONES: opnd = ALL_ONES;
          SA_MEMP: opnd = mem_val;
          default: opnd = '0;
        endcase
      end
    end else begin : g_second
      always_comb begin
        unique case (sel)
          SB_GEN:  opnd = reg_val;
          SB_ONES: opnd = ALL_ONES;
          default: opnd = mem_val;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/mop_alu_core.sv
module mop_alu_core
  import mop_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          c,
  output logic          z,
  output logic          n,
  output logic          v
);

  localparam int MSB = DW - 1;

  function automatic logic [DW:0] add_ext(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          cin);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  endfunction

  function automatic logic ovf_of(input logic xs, input logic ys,
                                  input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [DW:0]   sum_ext;
  logic          is_sub;
  logic [DW-1:0] b_eff;

  assign is_sub  = (op == 3'(OP_SUB));
  assign b_eff   = is_sub ? ~b : b;
  assign sum_ext = add_ext(a, b_eff, is_sub);

  always_comb begin
    c   = 1'b0;
    v   = 1'b0;
    res = '0;
    case (alu_op_e'(op))
      OP_ADD, OP_SUB: begin
        res = sum_ext[DW-1:0];
        c   = sum_ext[DW];
        v   = ovf_of(a[MSB], b_eff[MSB], sum_ext[MSB]);
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end

  assign z = (res == '0);
  assign n = res[MSB];

endmodule

// File: rtl/mop_alu_exec.sv
module mop_alu_exec
  import mop_alu_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_vld,
  input  logic [2:0]     issue_op,
  input  logic [1:0]     src_a_sel,
  input  logic [1:0]     src_b_sel,
  input  logic [RIW-1:0] dst_idx,
  input  logic [DW-1:0]  cnt_a_data,
  input  logic [AW-1:0]  ptr_b_data,
  input  logic [DW-1:0]  gen_b_data,
  input  logic [AW-1:0]  imm_addr,
  output logic           mem_a_ren,
  output logic [AW-1:0]  mem_a_addr,
  output logic           mem_b_ren,
  output logic [AW-1:0]  mem_b_addr,
  input  logic [DW-1:0]  mem_a_rdata,
  input  logic [DW-1:0]  mem_b_rdata,
  output logic           wr_en,
  output logic [RIW-1:0] wr_idx,
  output logic [DW-1:0]  wr_data,
  output logic           flag_c,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_v,
  output logic           err
);

  // named issue-side events
  logic issue_bad;
  logic issue_ok;

  assign issue_bad = !op_is_legal(issue_op) || (src_a_sel == SA_BAD);
  assign issue_ok  = issue_vld && !issue_bad;

  mop_addr_sel #(.DW(DW), .AW(AW)) addr_i (
    .issue_ok (issue_ok),
    .a_sel    (src_a_sel),
    .b_sel    (src_b_sel),
    .ptr_a    (cnt_a_data),
    .ptr_b    (ptr_b_data),
    .imm      (imm_addr),
    .ren_a    (mem_a_ren),
    .addr_a   (mem_a_addr),
    .ren_b    (mem_b_ren),
    .addr_b   (mem_b_addr)
  );

  // stage register: aligns register operands with scratchpad return
  logic           vld_q, err_q;
  logic [2:0]     op_q;
  logic [1:0]     a_sel_q, b_sel_q;
  logic [RIW-1:0] dst_q;
  logic [DW-1:0]  a_reg_q, b_reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= issue_ok;
      err_q <= issue_vld && issue_bad;
    end
    op_q    <= issue_op;
    a_sel_q <= src_a_sel;
    b_sel_q <= src_b_sel;
    dst_q   <= dst_idx;
    a_reg_q <= cnt_a_data;
    b_reg_q <= gen_b_data;
  end

  logic [DW-1:0] opnd_a, opnd_b;

  mop_src_mux #(.DW(DW), .POS(0)) mux_a_i (
    .sel (a_sel_q), .reg_val (a_reg_q), .mem_val (mem_a_rdata), .opnd (opnd_a)
  );

  mop_src_mux #(.DW(DW), .POS(1)) mux_b_i (
    .sel (b_sel_q), .reg_val (b_reg_q), .mem_val (mem_b_rdata), .opnd (opnd_b)
  );

  logic [DW-1:0] alu_res;
  logic          alu_c, alu_z, alu_n, alu_v;

  mop_alu_core #(.DW(DW)) core_i (
    .op  (op_q),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (alu_res),
    .c   (alu_c),
    .z   (alu_z),
    .n   (alu_n),
    .v   (alu_v)
  );

  assign wr_en   = vld_q;
  assign wr_idx  = dst_q;
  assign wr_data = alu_res;
  assign flag_c  = vld_q & alu_c;
  assign flag_z  = vld_q & alu_z;
  assign flag_n  = vld_q & alu_n;
  assign flag_v  = vld_q & alu_v;
  assign err     = err_q;

  // R9
  err_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && wr_en));

  // R6
  wr_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(issue_vld));

  // R9
  bad_src_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && src_a_sel == 2'd3) |=> (err && !wr_en));

  // R5
  ren_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_a_ren || mem_b_ren) |-> issue_ok);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> (!wr_en && !err));

  // R8
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_is_logic(op_q)) |-> (!flag_c && !flag_v));

endmodule

// File: tb/mop_alu_exec_tb_top.sv
`timescale 1ns/1ps
module mop_alu_exec_tb_top;

  localparam int DW = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_vld = 1'b0;
  logic [2:0]    issue_op = '0;
  logic [1:0]    src_a_sel = '0, src_b_sel = '0;
  logic [3:0]    dst_idx = '0;
  logic [DW-1:0] cnt_a_data = '0, gen_b_data = '0;
  logic [AW-1:0] ptr_b_data = '0, imm_addr = '0;
  logic          mem_a_ren, mem_b_ren;
  logic [AW-1:0] mem_a_addr, mem_b_addr;
  logic [DW-1:0] mem_a_rdata = '0, mem_b_rdata = '0;
  logic          wr_en, flag_c, flag_z, flag_n, flag_v, err;
  logic [3:0]    wr_idx;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mop_alu_exec dut_i (
    .clk, .rst_n, .issue_vld, .issue_op, .src_a_sel, .src_b_sel, .dst_idx,
    .cnt_a_data, .ptr_b_data, .gen_b_data, .imm_addr,
    .mem_a_ren, .mem_a_addr, .mem_b_ren, .mem_b_addr,
    .mem_a_rdata, .mem_b_rdata,
    .wr_en, .wr_idx, .wr_data, .flag_c, .flag_z, .flag_n, .flag_v, .err
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] adr);
    return ({16'h0, adr} * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  // scratchpad model: one cycle read latency
  always @(posedge clk) begin
    if (mem_a_ren) mem_a_rdata <= mem_word(mem_a_addr);
    if (mem_b_ren) mem_b_rdata <= mem_word(mem_b_addr);
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check the issue-cycle reads, then the result
  task automatic run_one(input int op, input int sa, input int sb,
                         input logic [DW-1:0] ca, input logic [DW-1:0] gb,
                         input logic [AW-1:0] pb, input logic [AW-1:0] im,
                         input logic [3:0] dst);
    bit bad;
    logic [DW-1:0] a, b, r;
    logic c, v;
    longint sr;
    issue_vld = 1'b1; issue_op = 3'(op); src_a_sel = 2'(sa); src_b_sel = 2'(sb);
    cnt_a_data = ca; gen_b_data = gb; ptr_b_data = pb; imm_addr = im;
    dst_idx = dst;
    bad = (op > 4) || (sa == 3);
    #1;
    chk(mem_a_ren == (!bad && sa == 2), "R5 ren_a", 32'(mem_a_ren), 32'(!bad && sa == 2));
    chk(mem_b_ren == (!bad && sb >= 2), "R5 ren_b", 32'(mem_b_ren), 32'(!bad && sb >= 2));
    if (!bad && sa == 2)
      chk(mem_a_addr == ca[AW-1:0], "R2 addr_a", 32'(mem_a_addr), 32'(ca[AW-1:0]));
    if (!bad && sb >= 2)
      chk(mem_b_addr == ((sb == 2) ? im : pb), "R3 addr_b", 32'(mem_b_addr),
          32'((sb == 2) ? im : pb));
    a = (sa == 0) ? ca : (sa == 1) ? 32'hFFFF_FFFF : mem_word(ca[AW-1:0]); // R4
    b = (sb == 0) ? gb : (sb == 1) ? 32'hFFFF_FFFF :
        (sb == 2) ? mem_word(im) : mem_word(pb);
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      0: begin
        r = a + b; c = ({32'h0, a} + {32'h0, b}) > 64'hFFFF_FFFF;
        sr = longint'($signed(a)) + longint'($signed(b));
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      1: begin
        r = a - b; c = (a >= b);
        sr = longint'($signed(a)) - longint'($signed(b));
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      default: r = '0;
    endcase
    @(negedge clk);
    issue_vld = 1'b0;
    if (bad) begin
      chk(err == 1'b1, "R9 err", 32'(err), 32'd1);
      chk(wr_en == 1'b0, "R9 wr_en", 32'(wr_en), 32'd0);
    end else begin
      chk(err == 1'b0, "R1 err", 32'(err), 32'd0);
      chk(wr_en == 1'b1, "R6 wr_en", 32'(wr_en), 32'd1);
      chk(wr_idx == dst, "R6 wr_idx", 32'(wr_idx), 32'(dst));
      chk(wr_data == r, (op > 1) ? "R1 logic data" : "R1 arith data", wr_data, r);
      chk(flag_z == (r == 0), "R7 flag_z", 32'(flag_z), 32'(r == 0));
      chk(flag_n == r[31], "R7 flag_n", 32'(flag_n), 32'(r[31]));
      chk(flag_c == c, (op > 1) ? "R8 flag_c" : "R7 flag_c", 32'(flag_c), 32'(c));
      chk(flag_v == v, (op > 1) ? "R8 flag_v" : "R7 flag_v", 32'(flag_v), 32'(v));
    end
  endtask

  initial begin
    logic [DW-1:0] pa [6];
    logic [DW-1:0] pbv [6];
    pa[0] = 32'h0;         pbv[0] = 32'h0;
    pa[1] = 32'hFFFF_FFFF; pbv[1] = 32'h1;
    pa[2] = 32'h7FFF_FFFF; pbv[2] = 32'h1;
    pa[3] = 32'h8000_0000; pbv[3] = 32'h1;
    pa[4] = 32'h8000_0000; pbv[4] = 32'h7FFF_FFFF;
    pa[5] = 32'h1234_5678; pbv[5] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R10
    chk(!wr_en && !err && !flag_c && !flag_z && !flag_n && !flag_v,
        "R10 in reset", 32'({wr_en, err, flag_c, flag_z, flag_n, flag_v}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !err && !flag_z, "R10 after reset",
        32'({wr_en, err, flag_z}), 32'd0);
    for (int op = 0; op < 8; op++)
      for (int sa = 0; sa < 4; sa++)
        for (int sb = 0; sb < 4; sb++)
          for (int p = 0; p < 10; p++) begin
            logic [DW-1:0] ca, gb;
            ca = (p < 6) ? pa[p] : $urandom();
            gb = (p < 6) ? pbv[p] : $urandom();
            run_one(op, sa, sb, ca, gb, 16'($urandom()), 16'($urandom()),
                    4'(op * 5 + sa * 3 + sb + p));
          end
    // R11: idle cycle with selects that would read memory
    issue_vld = 1'b0; src_a_sel = 2'd2; src_b_sel = 2'd3; issue_op = 3'd0;
    #1;
    chk(!mem_a_ren && !mem_b_ren, "R11 idle reads",
        32'({mem_a_ren, mem_b_ren}), 32'd0);
    @(negedge clk);
    chk(!wr_en && !err, "R11 idle result", 32'({wr_en, err}), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule